// File: doc/BRIEF.md
# Tri-State Register Bit Override Unit

This unit keeps thirty-two override flags for a bank of target register bits. Each flag is in one of three states: pass-through, forced low or forced high. A state is stored as a value bit and an enable bit. A command sequencer changes single flags with short strobes. The host reads and writes the whole flag set through two 32-bit words, each covering sixteen flags.

Two outputs come from the 32-bit target vector. The effective vector is what internal logic uses. The readback vector is what a host read of those bits returns. A global enable switches the forcing on and off without touching the stored state. A readback-mode input chooses whether reads show the original bits or the forced ones.

Flag 16 forces no target bit. It drives a framebuffer-pause request instead. Combined with an acknowledge from the memory side, it also produces a paused event.

Top module: `flag_override_unit`

## Requirements
- R1: After reset every flag is pass-through with value 0 and enable 0, so both host words read 0 and `pause_req` is 0.
- R2: A strobe on `seq_valid` acts on flag `seq_idx` from the next cycle. The `seq_cmd` value 2'b01 sets enable=1 and value=1. The value 2'b10 sets enable=1 and value=0. The value 2'b00 clears the enable and leaves the value bit as it was. The value 2'b11 changes nothing. These codes are bits 6:5 of the flag opcodes 0x80/0xa0/0xc0.
- R3: `host_rd_lo` carries the values of flags 0-15 in bits 15:0 and their enables in bits 31:16. `host_rd_hi` uses the same layout for flags 16-31.
- R4: A write with `host_wr_en` loads `host_wr_data` into the word picked by `host_wr_sel` (0 = flags 0-15, 1 = flags 16-31), in the R3 layout. It is visible from the next cycle.
- R5: A host write and a sequencer strobe in the same cycle both take effect. For the flag named by the strobe, the sequencer result wins.
- R6: A target bit other than bit 16 appears on `tgt_eff` as the flag value when both its enable and `global_en` are 1. Otherwise it appears as `tgt_in`.
- R7: With `global_en` at 0, `tgt_eff` equals `tgt_in`, but strobes and host writes still update the flag state.
- R8: With `read_forced` at 0, `tgt_rd` equals `tgt_in`. With `read_forced` at 1, `tgt_rd` equals `tgt_eff`.
- R9: Bit 16 of `tgt_eff` and of `tgt_rd` always equals bit 16 of `tgt_in`.
- R10: `pause_req` is 1 exactly when flag 16 has enable=1 and value=1, whatever the state of `global_en`.
- R11: `paused_evt` is 1 exactly when `pause_req` and `pause_ack` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_valid | input | 1 | Sequencer flag strobe |
| seq_cmd | input | 2 | Flag command (R2 codes) |
| seq_idx | input | 5 | Flag addressed by the strobe |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_sel | input | 1 | Word select: 0 low flags, 1 high flags |
| host_wr_data | input | 32 | Host write word |
| host_rd_lo | output | 32 | Flag word for flags 0-15 |
| host_rd_hi | output | 32 | Flag word for flags 16-31 |
| global_en | input | 1 | Enables forcing of target bits |
| read_forced | input | 1 | Readback mode: 1 shows forced bits |
| tgt_in | input | 32 | Target bits before override |
| tgt_eff | output | 32 | Target bits as used internally |
| tgt_rd | output | 32 | Target bits as returned to host reads |
| pause_ack | input | 1 | Memory side reports the pause is done |
| pause_req | output | 1 | Framebuffer pause request |
| paused_evt | output | 1 | Pause requested and acknowledged |

## Verification
A host word write and a sequencer strobe can land in the same cycle. The write may cover the strobed flag or the other half of the bank. The bench provokes this in a directed step, where an all-ones write to the low word meets a force-low on flag 2. It also provokes it many times in a random phase in which both strobes fire freely. The behavioural model applies the host word first and the strobe after it. Any other order in the design shows up as a mismatch on the host words one cycle later.

// File: rtl/flag_ovr_pkg.sv
package flag_ovr_pkg;
    parameter int FLAG_CNT = 32;
    localparam int IDX_W = $clog2(FLAG_CNT);
    localparam int HALF  = FLAG_CNT / 2;

    typedef enum logic [1:0] {
        CMD_UNSET  = 2'b00,
        CMD_FORCE1 = 2'b01,
        CMD_FORCE0 = 2'b10,
        CMD_NOP    = 2'b11
    } flag_cmd_e;

    typedef struct packed {
        logic [FLAG_CNT-1:0] val;
        logic [FLAG_CNT-1:0] en;
    } flag_bank_t;
endpackage

// File: rtl/flag_state_reg.sv
module flag_state_reg
    import flag_ovr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_valid,
    input  logic [1:0]       seq_cmd,
    input  logic [IDX_W-1:0] seq_idx,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [2*HALF-1:0] wr_data,
    output flag_bank_t       bank_q
);
    flag_bank_t bank_d;

    always_comb begin
        bank_d = bank_q;
        // host word first, sequencer strobe last so it wins on its flag
        if (wr_en) begin
            if (wr_sel) begin
                bank_d.val[FLAG_CNT-1:HALF] = wr_data[HALF-1:0];
                bank_d.en[FLAG_CNT-1:HALF]  = wr_data[2*HALF-1:HALF];
            end else begin
                bank_d.val[HALF-1:0] = wr_data[HALF-1:0];
                bank_d.en[HALF-1:0]  = wr_data[2*HALF-1:HALF];
            end
        end
        if (seq_valid) begin
            case (flag_cmd_e'(seq_cmd))
                CMD_UNSET: bank_d.en[seq_idx] = 1'b0;
                CMD_FORCE1: begin
                    bank_d.en[seq_idx]  = 1'b1;
                    bank_d.val[seq_idx] = 1'b1;
                end
                CMD_FORCE0: begin
                    bank_d.en[seq_idx]  = 1'b1;
                    bank_d.val[seq_idx] = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end
endmodule

// File: rtl/flag_apply.sv
module flag_apply
    import flag_ovr_pkg::*;
#(
    parameter int PAUSE_IDX = 16
) (
    input  flag_bank_t          bank,
    input  logic                global_en,
    input  logic                read_forced,
    input  logic [FLAG_CNT-1:0] tgt_in,
    output logic [FLAG_CNT-1:0] tgt_eff,
    output logic [FLAG_CNT-1:0] tgt_rd
);
    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_bit
        if (g == PAUSE_IDX) begin : g_pause
            assign tgt_eff[g] = tgt_in[g];
        end else begin : g_ovr
            assign tgt_eff[g] = (bank.en[g] && global_en) ? bank.val[g] : tgt_in[g];
        end
    end

    assign tgt_rd = read_forced ? tgt_eff : tgt_in;
endmodule

// File: rtl/host_view.sv
module host_view
    import flag_ovr_pkg::*;
(
    input  flag_bank_t          bank,
    output logic [2*HALF-1:0]   word_lo,
    output logic [2*HALF-1:0]   word_hi
);
    assign word_lo = {bank.en[HALF-1:0], bank.val[HALF-1:0]};
    assign word_hi = {bank.en[FLAG_CNT-1:HALF], bank.val[FLAG_CNT-1:HALF]};
endmodule

// File: rtl/flag_override_unit.sv
module flag_override_unit
    import flag_ovr_pkg::*;
#(
    parameter int PAUSE_IDX = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seq_valid,
    input  logic [1:0]  seq_cmd,
    input  logic [4:0]  seq_idx,
    input  logic        host_wr_en,
    input  logic        host_wr_sel,
    input  logic [31:0] host_wr_data,
    output logic [31:0] host_rd_lo,
    output logic [31:0] host_rd_hi,
    input  logic        global_en,
    input  logic        read_forced,
    input  logic [31:0] tgt_in,
    output logic [31:0] tgt_eff,
    output logic [31:0] tgt_rd,
    input  logic        pause_ack,
    output logic        pause_req,
    output logic        paused_evt
);
    flag_bank_t bank_q;

    flag_state_reg u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_valid (seq_valid),
        .seq_cmd   (seq_cmd),
        .seq_idx   (seq_idx),
        .wr_en     (host_wr_en),
        .wr_sel    (host_wr_sel),
        .wr_data   (host_wr_data),
        .bank_q    (bank_q)
    );

    flag_apply #(.PAUSE_IDX(PAUSE_IDX)) u_apply (
        .bank        (bank_q),
        .global_en   (global_en),
        .read_forced (read_forced),
        .tgt_in      (tgt_in),
        .tgt_eff     (tgt_eff),
        .tgt_rd      (tgt_rd)
    );

    host_view u_view (
        .bank    (bank_q),
        .word_lo (host_rd_lo),
        .word_hi (host_rd_hi)
    );

    // pause line follows the stored state only, never the global enable
    assign pause_req  = bank_q.en[PAUSE_IDX] & bank_q.val[PAUSE_IDX];
    assign paused_evt = pause_req & pause_ack;
endmodule

// File: rtl/flag_override_unit_chk.sv
module flag_override_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        seq_valid,
    input logic [1:0]  seq_cmd,
    input logic [4:0]  seq_idx,
    input logic [31:0] host_rd_lo,
    input logic [31:0] host_rd_hi,
    input logic        global_en,
    input logic        read_forced,
    input logic [31:0] tgt_in,
    input logic [31:0] tgt_eff,
    input logic [31:0] tgt_rd,
    input logic        pause_ack,
    input logic        pause_req,
    input logic        paused_evt
);
    logic [31:0] en_vec, val_vec;
    assign en_vec  = {host_rd_hi[31:16], host_rd_lo[31:16]};
    assign val_vec = {host_rd_hi[15:0], host_rd_lo[15:0]};

    assert_force1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && seq_cmd == 2'b01) |=> (en_vec[$past(seq_idx)] && val_vec[$past(seq_idx)]));

    assert_force0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && seq_cmd == 2'b10) |=> (en_vec[$past(seq_idx)] && !val_vec[$past(seq_idx)]));

    assert_unset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && seq_cmd == 2'b00) |=> !en_vec[$past(seq_idx)]);

    assert_no_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |-> (tgt_eff == tgt_in));

    assert_plain_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !read_forced |-> (tgt_rd == tgt_in));

    assert_bit16_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_eff[16] == tgt_in[16]) && (tgt_rd[16] == tgt_in[16]));

    assert_pause_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req == (en_vec[16] && val_vec[16]));

    assert_paused_evt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        paused_evt |-> (pause_req && pause_ack));
endmodule

bind flag_override_unit flag_override_unit_chk u_chk (.*);

// File: tb/flag_override_unit_test.sv
module flag_override_unit_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seq_valid = 1'b0;
    logic [1:0] seq_cmd = 2'b11;
    logic [4:0] seq_idx = '0;
    logic host_wr_en = 1'b0;
    logic host_wr_sel = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic global_en = 1'b0;
    logic read_forced = 1'b0;
    logic [31:0] tgt_in = '0;
    logic pause_ack = 1'b0;
    logic [31:0] host_rd_lo, host_rd_hi, tgt_eff, tgt_rd;
    logic pause_req, paused_evt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_val = '0;
    logic [31:0] m_en = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_override_unit uut (
        .clk(clk), .rst_n(rst_n),
        .seq_valid(seq_valid), .seq_cmd(seq_cmd), .seq_idx(seq_idx),
        .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
        .host_rd_lo(host_rd_lo), .host_rd_hi(host_rd_hi),
        .global_en(global_en), .read_forced(read_forced),
        .tgt_in(tgt_in), .tgt_eff(tgt_eff), .tgt_rd(tgt_rd),
        .pause_ack(pause_ack), .pause_req(pause_req), .paused_evt(paused_evt)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_val = '0;
            m_en  = '0;
        end else begin
            if (host_wr_en) begin
                for (int i = 0; i < 16; i++) begin
                    m_val[i + 16*host_wr_sel] = host_wr_data[i];
                    m_en[i + 16*host_wr_sel]  = host_wr_data[16+i];
                end
            end
            if (seq_valid) begin
                if (seq_cmd == 2'b00) m_en[seq_idx] = 1'b0;
                else if (seq_cmd == 2'b01) begin m_en[seq_idx] = 1'b1; m_val[seq_idx] = 1'b1; end
                else if (seq_cmd == 2'b10) begin m_en[seq_idx] = 1'b1; m_val[seq_idx] = 1'b0; end
            end
        end
    endtask

    task automatic compare_all();
        logic [31:0] e_eff, e_rd;
        logic e_p;
        for (int i = 0; i < 32; i++)
            e_eff[i] = (i != 16 && m_en[i] && global_en) ? m_val[i] : tgt_in[i];
        e_rd = read_forced ? e_eff : tgt_in;
        e_p = m_en[16] & m_val[16];
        chk("R3 lo", host_rd_lo, {m_en[15:0], m_val[15:0]});
        chk("R3 hi", host_rd_hi, {m_en[31:16], m_val[31:16]});
        chk("R6 eff", tgt_eff, e_eff);
        chk("R8 rd", tgt_rd, e_rd);
        chk("R10 pause_req", {31'd0, pause_req}, {31'd0, e_p});
        chk("R11 paused", {31'd0, paused_evt}, {31'd0, e_p & pause_ack});
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic strobe(logic [1:0] c, logic [4:0] idx);
        seq_valid = 1'b1; seq_cmd = c; seq_idx = idx;
        tick();
        seq_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 lo", host_rd_lo, 32'h0);
        chk("R1 hi", host_rd_hi, 32'h0);
        chk("R1 pause", {31'd0, pause_req}, 32'h0);

        strobe(2'b01, 5'd3);
        chk("R2 force1", host_rd_lo, 32'h0008_0008);
        strobe(2'b10, 5'd3);
        chk("R2 force0", host_rd_lo, 32'h0008_0000);
        strobe(2'b00, 5'd3);
        strobe(2'b01, 5'd5);
        strobe(2'b00, 5'd5);
        chk("R2 unset keeps value", host_rd_lo, 32'h0000_0020);
        strobe(2'b11, 5'd5);
        chk("R2 nop", host_rd_lo, 32'h0000_0020);

        host_wr_en = 1'b1; host_wr_sel = 1'b1; host_wr_data = 32'h00A5_00F0;
        tick();
        host_wr_en = 1'b0;
        chk("R4 hi write", host_rd_hi, 32'h00A5_00F0);
        chk("R4 lo untouched", host_rd_lo, 32'h0000_0020);

        global_en = 1'b1; tgt_in = 32'h0;
        tick();
        chk("R6 forced", tgt_eff, 32'h00A0_0000);
        tgt_in = 32'h0001_0000;
        tick();
        chk("R9 bit16", tgt_eff, 32'h00A1_0000);

        global_en = 1'b0; tgt_in = 32'h0;
        strobe(2'b01, 5'd0);
        chk("R7 no force", tgt_eff, 32'h0);
        chk("R7 state moves", host_rd_lo, 32'h0001_0021);

        global_en = 1'b1; read_forced = 1'b0;
        tick();
        chk("R8 plain", tgt_rd, 32'h0);
        read_forced = 1'b1;
        tick();
        chk("R8 forced", tgt_rd, 32'h00A0_0001);

        global_en = 1'b0;
        strobe(2'b01, 5'd16);
        chk("R10 pause", {31'd0, pause_req}, 32'h1);
        chk("R11 no ack", {31'd0, paused_evt}, 32'h0);
        pause_ack = 1'b1;
        tick();
        chk("R11 ack", {31'd0, paused_evt}, 32'h1);

        host_wr_en = 1'b1; host_wr_sel = 1'b0; host_wr_data = 32'hFFFF_FFFF;
        strobe(2'b10, 5'd2);
        host_wr_en = 1'b0;
        chk("R5 collision", host_rd_lo, 32'hFFFF_FFFB);

        for (int n = 0; n < 4000; n++) begin
            seq_valid    = ($urandom % 3) != 0;
            seq_cmd      = 2'($urandom);
            seq_idx      = 5'($urandom);
            host_wr_en   = ($urandom % 5) == 0;
            host_wr_sel  = 1'($urandom);
            host_wr_data = $urandom;
            global_en    = ($urandom % 4) != 0;
            read_forced  = 1'($urandom);
            tgt_in       = $urandom;
            pause_ack    = 1'($urandom);
            if (n == 2000) rst_n = 1'b0;
            if (n == 2003) rst_n = 1'b1;
            tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule